// File: doc/BRIEF.md
# Page-Map Address Translation Unit

This block converts CPU virtual addresses into physical addresses through a page map that is indexed directly by the virtual page number. Pages are 4 KB. The low 12 address bits pass through unchanged. The upper bits select a map entry, and that entry supplies the physical page number. A lookup whose page is not resident, or whose address lies above the implemented page range, does not translate. It raises a page fault and reports the faulting virtual page number, so that software can bring the page in. The block never moves data itself.

A separate programming port lets software write any entry and read any entry back. Software can therefore swap the whole map when the running program changes. The block sets a per-entry modified flag whenever a write access hits a resident page. When software evicts a page, it reads this flag to decide whether the page must be written back.

Top module: `page_xlate`

## Requirements
- R1: After reset, every map entry is non-resident and not modified, `pa_valid` and `fault` are low, and any lookup faults until an entry is programmed.
- R2: A lookup to a resident page asserts `pa_valid` one cycle after `lk_valid`. On that cycle `pa_addr` holds the entry's physical page number in bits [PA_W-1:12] and the lookup's address bits [11:0] in bits [11:0].
- R3: A lookup to a non-resident page asserts `fault` one cycle after `lk_valid` and sets `fault_vpn` to the lookup's address bits [31:12].
- R4: A lookup with any nonzero address bit in [31:12+IDX_W] faults, whatever the entry selected by its low index bits holds.
- R5: On the cycle after `lk_valid` is high, exactly one of `pa_valid` and `fault` is high. On the cycle after `lk_valid` is low, both are low.
- R6: A write lookup (`lk_write`=1) that translates sets the entry's modified flag. A read lookup leaves the flag unchanged.
- R7: A write lookup that faults changes no modified flag.
- R8: A map write (`map_we`) to entry `map_idx` loads the resident bit from `map_wr_res` and the physical page number from `map_wr_ppn`, and clears the modified flag. The change is visible from the next cycle.
- R9: When a lookup and a map write address the same entry in the same cycle, the lookup uses the entry's old contents.
- R10: `map_rd_res`, `map_rd_mod` and `map_rd_ppn` show the current contents of entry `map_idx` without delay.
- R11: When a translating write lookup and a map write hit the same entry in the same cycle, the map write decides the result and the modified flag ends up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request strobe |
| lk_write | input | 1 | Lookup is a write access |
| lk_vaddr | input | VA_W | Virtual address |
| pa_valid | output | 1 | Translation succeeded (registered) |
| pa_addr | output | PPN_W+OFF_W | Physical address |
| fault | output | 1 | Page fault (registered) |
| fault_vpn | output | VA_W-OFF_W | Faulting virtual page number |
| map_we | input | 1 | Map entry write strobe |
| map_idx | input | IDX_W | Entry selected for write and readback |
| map_wr_res | input | 1 | Resident bit to write |
| map_wr_ppn | input | PPN_W | Physical page number to write |
| map_rd_res | output | 1 | Resident bit of the selected entry |
| map_rd_mod | output | 1 | Modified flag of the selected entry |
| map_rd_ppn | output | PPN_W | Physical page number of the selected entry |

## Verification
The hardest cases to reach are the ones where a lookup and a map write land on the same entry in the same cycle. This matters most when the lookup is a write, because then the modified flag is pulled two ways at once. Random stimulus reaches these cases only by chance. Directed steps therefore force them. The random phase also confines most indices to sixteen entries, so that collisions, evictions and re-mappings recur often. Occasional out-of-range upper address bits are mixed in to exercise the range fault.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 8,
  parameter int PPN_W = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic                   lk_write,
  input  logic [VA_W-1:0]        lk_vaddr,
  output logic                   pa_valid,
  output logic [PPN_W+OFF_W-1:0] pa_addr,
  output logic                   fault,
  output logic [VA_W-OFF_W-1:0]  fault_vpn,
  input  logic                   map_we,
  input  logic [IDX_W-1:0]       map_idx,
  input  logic                   map_wr_res,
  input  logic [PPN_W-1:0]       map_wr_ppn,
  output logic                   map_rd_res,
  output logic                   map_rd_mod,
  output logic [PPN_W-1:0]       map_rd_ppn
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int DEPTH = 1 << IDX_W;
  localparam int HI_W  = VPN_W - IDX_W;

  logic [DEPTH-1:0] res_q, mod_q;
  logic [PPN_W-1:0] ppn_q [DEPTH];
  logic             oor;

  wire [IDX_W-1:0] idx = lk_vaddr[OFF_W +: IDX_W];

  generate
    if (HI_W > 0) begin : g_range
      assign oor = |lk_vaddr[VA_W-1:OFF_W+IDX_W];
    end else begin : g_full
      assign oor = 1'b0;
    end
  endgenerate

  wire hit = !oor && res_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q     <= '0;
      mod_q     <= '0;
      pa_valid  <= 1'b0;
      fault     <= 1'b0;
      pa_addr   <= '0;
      fault_vpn <= '0;
    end else begin
      pa_valid <= lk_valid && hit;
      fault    <= lk_valid && !hit;
      if (lk_valid) begin
        pa_addr   <= {ppn_q[idx], lk_vaddr[OFF_W-1:0]};
        fault_vpn <= lk_vaddr[VA_W-1:OFF_W];
      end
      if (lk_valid && lk_write && hit) mod_q[idx] <= 1'b1;
      if (map_we) begin
        res_q[map_idx] <= map_wr_res;
        mod_q[map_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (map_we) ppn_q[map_idx] <= map_wr_ppn;
  end

  assign map_rd_res = res_q[map_idx];
  assign map_rd_mod = mod_q[map_idx];
  assign map_rd_ppn = ppn_q[map_idx];

  p_one_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (pa_valid ^ fault));

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!pa_valid && !fault));

  p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!pa_valid || pa_addr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

  p_fault_vpn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!fault || fault_vpn == $past(lk_vaddr[VA_W-1:OFF_W])));

  p_range_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && oor) |=> fault);

  p_map_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |=> (res_q[$past(map_idx)] == $past(map_wr_res) && !mod_q[$past(map_idx)]));

  p_mod_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_write && !map_we) |=> (!pa_valid || mod_q[$past(idx)]));
endmodule

// File: tb/test_page_xlate.sv
module test_page_xlate;
  localparam int VA_W = 32, OFF_W = 12, IDX_W = 8, PPN_W = 20;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0, map_we = 0, map_wr_res = 0;
  logic [VA_W-1:0] lk_vaddr = '0;
  logic [IDX_W-1:0] map_idx = '0;
  logic [PPN_W-1:0] map_wr_ppn = '0;
  logic pa_valid, fault, map_rd_res, map_rd_mod;
  logic [PPN_W+OFF_W-1:0] pa_addr;
  logic [VA_W-OFF_W-1:0] fault_vpn;
  logic [PPN_W-1:0] map_rd_ppn;

  page_xlate #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PPN_W(PPN_W)) i_page_xlate (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
    .pa_valid(pa_valid), .pa_addr(pa_addr), .fault(fault), .fault_vpn(fault_vpn),
    .map_we(map_we), .map_idx(map_idx), .map_wr_res(map_wr_res), .map_wr_ppn(map_wr_ppn),
    .map_rd_res(map_rd_res), .map_rd_mod(map_rd_mod), .map_rd_ppn(map_rd_ppn));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_res [DEPTH];
  bit m_mod [DEPTH];
  logic [PPN_W-1:0] m_ppn [DEPTH];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit in_range(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W+IDX_W] == '0;
  endfunction

  task automatic step(input bit v, input bit w, input logic [VA_W-1:0] va,
                      input bit we, input logic [IDX_W-1:0] mi, input bit wres,
                      input logic [PPN_W-1:0] wppn, input string tag);
    logic [IDX_W-1:0] ix;
    bit hit, e_pv, e_f;
    logic [PPN_W+OFF_W-1:0] e_pa;
    lk_valid = v; lk_write = w; lk_vaddr = va;
    map_we = we; map_idx = mi; map_wr_res = wres; map_wr_ppn = wppn;
    #1;
    chk(map_rd_res == m_res[mi] && map_rd_mod == m_mod[mi] && (!m_res[mi] || map_rd_ppn == m_ppn[mi]),
        "R10 readback", {map_rd_res, map_rd_mod, map_rd_ppn}, {m_res[mi], m_mod[mi], m_ppn[mi]});
    ix = va[OFF_W +: IDX_W];
    hit = in_range(va) && m_res[ix];
    e_pv = v && hit;
    e_f = v && !hit;
    e_pa = {m_ppn[ix], va[OFF_W-1:0]};
    if (v && w && hit) m_mod[ix] = 1'b1;
    if (we) begin m_res[mi] = wres; m_mod[mi] = 1'b0; m_ppn[mi] = wppn; end
    @(negedge clk);
    chk(pa_valid == e_pv && fault == e_f, {tag, " R5 result flags"}, {pa_valid, fault}, {e_pv, e_f});
    if (e_pv) chk(pa_addr == e_pa, {tag, " R2 physical address"}, pa_addr, e_pa);
    if (e_f) chk(fault_vpn == va[VA_W-1:OFF_W], {tag, " R3 fault vpn"}, fault_vpn, va[VA_W-1:OFF_W]);
    lk_valid = 0; map_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_res[i] = 0; m_mod[i] = 0; m_ppn[i] = '0; end
    map_idx = 8'd3;
    #5;
    chk(!pa_valid && !fault, "R1 reset outputs", {pa_valid, fault}, 0);
    chk(!map_rd_res && !map_rd_mod, "R1 reset entry", {map_rd_res, map_rd_mod}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    step(1, 0, 32'h0000_3abc, 0, 8'd3, 0, '0, "R1 lookup after reset");
    step(1, 0, 32'h0000_3abc, 1, 8'd3, 1, 20'h12345, "R9 R8 map write same cycle");
    step(1, 0, 32'h0000_3abc, 0, 8'd3, 0, '0, "R2 R6 read hit");
    step(1, 1, 32'h0000_3ff0, 0, 8'd3, 0, '0, "R6 write hit");
    step(0, 0, '0, 0, 8'd3, 0, '0, "R6 idle");
    step(1, 0, 32'h8000_3abc, 0, 8'd3, 0, '0, "R4 upper bit set");
    step(1, 1, 32'h0010_3abc, 0, 8'd3, 0, '0, "R4 R7 write out of range");
    step(1, 1, 32'h0000_5123, 0, 8'd5, 0, '0, "R7 write non-resident");
    step(1, 0, 32'h0000_3001, 1, 8'd3, 1, 20'h0abcd, "R9 remap same cycle");
    step(1, 1, 32'h0000_3002, 0, 8'd3, 0, '0, "R8 new mapping");
    step(1, 1, 32'h0000_3003, 1, 8'd3, 1, 20'h00777, "R11 write lookup and map write");
    step(0, 0, '0, 0, 8'd3, 0, '0, "R11 mod cleared");
    step(1, 0, 32'h0000_3004, 1, 8'd3, 0, '0, "R9 evict same cycle");
    step(1, 0, 32'h0000_3004, 0, 8'd3, 0, '0, "R8 evicted faults");
    void'($urandom(32'd1357));
    for (int n = 0; n < 3000; n++) begin
      logic [VA_W-1:0] va;
      va = $urandom;
      va[VA_W-1:OFF_W+4] = '0;
      if (($urandom % 20) == 0) va[VA_W-1 - ($urandom % (VA_W-OFF_W-IDX_W))] = 1'b1;
      step(($urandom % 4) != 0, $urandom % 2, va, ($urandom % 5) == 0,
           IDX_W'($urandom % 16), ($urandom % 4) != 0, PPN_W'($urandom), "R2/R3/R6/R8 random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule